// File: doc/BRIEF.md
# Charge-Path Guard Controller

This block decides, cycle by cycle, whether the series power switch in a battery charging path may conduct. It reads digital flags from external comparators (input overvoltage, battery overvoltage, overcurrent, and a pair of die-temperature flags for trip and release), plus a power-on-reset flag and an active-high disable. From these it drives a switch-enable, a turn-off speed select, a soft-start ramp code for the switch driver, and an active-low warning.

After power-on reset or re-enable, the controller waits a long settling delay and then ramps the switch on over a fixed number of ticks. Input overvoltage removes the switch at once, with no blanking, and selects the fast turn-off path. Battery overvoltage and overcurrent are each filtered by a blanking timer. Each blanked fault off is counted in its own saturating counter, and the sixteenth such event of either kind latches the switch off until a power cycle or an enable toggle. Every duration is a parameter counted in a fixed-rate tick derived from the clock.

Top module: `chg_guard`

## Requirements
- R1: While `por_i` is high, `sw_on_o` is 0, `ramp_o` is 0, `fast_off_o` is 0 and `warn_n_o` is 1 (no other fault present).
- R2: After `por_i` falls, `sw_on_o` rises after (SETTLE_TICKS + 2^RAMP_W − 1) ticks (± one tick). During that time `ramp_o` stays 0 through the settling wait, then rises by exactly one per tick from 0 to all ones. `sw_on_o` is 1 only with `ramp_o` at all ones.
- R3: One cycle after `in_ov_i` is seen high, `sw_on_o` is 0, `ramp_o` is 0 and `fast_off_o` is 1 (1 selects the fast turn-off path). No blanking applies.
- R4: When `in_ov_i` falls, the full settling wait and the ramp run again. If `in_ov_i` is high through the settling wait, the switch never turns on.
- R5: `bat_ov_i` turns the switch off only after staying high for BLANK_BOV consecutive ticks while the switch is ramping or on. A shorter pulse has no effect on `sw_on_o` or `warn_n_o`. The resulting turn-off leaves `fast_off_o` at 0.
- R6: `oc_i` behaves in the same way with its own window of BLANK_OC ticks, and also leaves `fast_off_o` at 0.
- R7: After a blanked turn-off that has not latched, the ramp restarts from 0 on the cycle after both `bat_ov_i` and `oc_i` are low, with no settling wait. `sw_on_o` returns after 2^RAMP_W − 1 ticks.
- R8: Battery-overvoltage and overcurrent events are counted separately. The 2^EVT_W-th event of one kind (16 by default) latches the switch off: `sw_on_o` stays 0 whatever the fault flags do, and `warn_n_o` stays 0. Fewer events always allow recovery.
- R9: `ot_trip_i` forces `sw_on_o` to 0 within two cycles. The switch stays off until `ot_release_i` is seen, and the trip flag wins when both are high. After release the ramp restarts without a settling wait.
- R10: `dis_i` high forces `sw_on_o` to 0 on the next cycle with `fast_off_o` at 0. When it falls, both event counters and the latch are clear and the settling wait runs again. A `por_i` pulse has the same clearing effect.
- R11: `warn_n_o` is 0 while input overvoltage is registered, while the temperature trip is held, while the switch is off after a blanked fault, and while latched. It is 1 while the switch ramps or conducts (including inside a blanking window) and while it is held off by `por_i` or `dis_i` with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| por_i | input | 1 | Power-on-reset flag, high while supply is below threshold |
| dis_i | input | 1 | Disable, high shuts the switch off |
| in_ov_i | input | 1 | Input overvoltage comparator flag |
| bat_ov_i | input | 1 | Battery overvoltage comparator flag |
| oc_i | input | 1 | Overcurrent comparator flag |
| ot_trip_i | input | 1 | Die temperature above trip point |
| ot_release_i | input | 1 | Die temperature below release point |
| sw_on_o | output | 1 | Switch fully enabled |
| fast_off_o | output | 1 | 1 selects the fast turn-off path |
| ramp_o | output | RAMP_W | Soft-start ramp code |
| warn_n_o | output | 1 | Active-low protection warning |

## Verification
A wrong state here shows up as timing at the ports. A lost settling count shortens the time from release to `sw_on_o` by whole ticks, and this shows on the first power-up. A miscounted event counter shows up only on the sixteenth fault, either as a latch that never happens or as one that comes early. For that reason the bench repeats each blanked fault until the latch is reached. A blanking timer that does not restart shows up as a short pulse that removes the switch, and that happens within one window.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_SETTLE = 3'd1,
      ST_RAMP   = 3'd2,
      ST_ON     = 3'd3,
      ST_RETRY  = 3'd4,
      ST_LOCK   = 3'd5
   } guard_st_e;

   localparam int unsigned N_BLANKED = 2;
   localparam int unsigned IDX_BOV   = 0;
   localparam int unsigned IDX_OC    = 1;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
   parameter int unsigned TICK_DIV = 200
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   import chg_guard_pkg::*;

   localparam int unsigned PW = cnt_w(TICK_DIV);
   localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (pre_q == LAST)  pre_q <= '0;
      else                     pre_q <= pre_q + 1'b1;
   end

   assign tick_o = (pre_q == LAST);

   if (TICK_DIV > 1) begin : g_spacing
      // R2: ticks are evenly spaced, never back to back
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/chg_blank_filt.sv
module chg_blank_filt #(
   parameter int unsigned BLANK_TICKS = 180,
   parameter int unsigned EVT_W       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   input  logic arm_i,
   input  logic flag_i,
   output logic evt_o,
   output logic last_o
);
   import chg_guard_pkg::*;

   localparam int unsigned BW = cnt_w(BLANK_TICKS);
   localparam logic [BW-1:0]    BLK_END = BW'(BLANK_TICKS - 1);
   localparam logic [EVT_W-1:0] EVT_MAX = EVT_W'((1 << EVT_W) - 1);

   logic [BW-1:0]    blk_q;
   logic [EVT_W-1:0] evt_q;

   assign evt_o  = arm_i & flag_i & tick_i & (blk_q == BLK_END);
   assign last_o = (evt_q == EVT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             blk_q <= '0;
      else if (!arm_i || !flag_i)             blk_q <= '0;
      else if (tick_i && blk_q != BLK_END)    blk_q <= blk_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         evt_q <= '0;
      else if (clr_i)                     evt_q <= '0;
      else if (evt_o && !last_o)          evt_q <= evt_q + 1'b1;
   end

   // R5 (and R6 for the overcurrent instance): an event needs a held flag
   assert_evt_needs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(flag_i) && $past(arm_i));

   // R8: the count saturates rather than wrapping back to zero
   assert_evt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !clr_i) |=> last_o);

endmodule

// File: rtl/chg_seq.sv
module chg_seq #(
   parameter int unsigned SETTLE_TICKS = 10000,
   parameter int unsigned RAMP_W       = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    stop_i,
   input  logic                    in_ov_i,
   input  logic                    ot_hot_i,
   input  logic                    hold_i,
   input  logic                    evt_i,
   input  logic                    lock_i,
   output chg_guard_pkg::guard_st_e st_o,
   output logic [RAMP_W-1:0]       ramp_o,
   output logic                    sw_on_o,
   output logic                    fast_o
);
   import chg_guard_pkg::*;

   localparam int unsigned SW = cnt_w(SETTLE_TICKS);
   localparam logic [SW-1:0]     SET_END  = SW'(SETTLE_TICKS - 1);
   localparam logic [RAMP_W-1:0] RAMP_PEN = RAMP_W'((1 << RAMP_W) - 2);

   guard_st_e         st_q, st_d;
   logic [SW-1:0]     set_q, set_d;
   logic [RAMP_W-1:0] ramp_q, ramp_d;
   logic              fast_q;

   always_comb begin
      st_d   = st_q;
      set_d  = set_q;
      ramp_d = ramp_q;
      if (stop_i) begin
         st_d   = ST_OFF;
         set_d  = '0;
         ramp_d = '0;
      end else if (st_q == ST_LOCK) begin
         st_d = ST_LOCK;
      end else if (in_ov_i) begin
         st_d   = ST_SETTLE;
         set_d  = '0;
         ramp_d = '0;
      end else begin
         unique case (st_q)
            ST_OFF: begin
               st_d  = ST_SETTLE;
               set_d = '0;
            end
            ST_SETTLE: begin
               if (tick_i) begin
                  if (set_q == SET_END) begin
                     set_d  = '0;
                     ramp_d = '0;
                     st_d   = ot_hot_i ? ST_RETRY : ST_RAMP;
                  end else begin
                     set_d = set_q + 1'b1;
                  end
               end
            end
            ST_RAMP, ST_ON: begin
               if (ot_hot_i) begin
                  st_d   = ST_RETRY;
                  ramp_d = '0;
               end else if (lock_i) begin
                  st_d   = ST_LOCK;
                  ramp_d = '0;
               end else if (evt_i) begin
                  st_d   = ST_RETRY;
                  ramp_d = '0;
               end else if (st_q == ST_RAMP && tick_i) begin
                  ramp_d = ramp_q + 1'b1;
                  if (ramp_q == RAMP_PEN) st_d = ST_ON;
               end
            end
            ST_RETRY: begin
               if (!hold_i && !ot_hot_i) begin
                  st_d   = ST_RAMP;
                  ramp_d = '0;
               end
            end
            default: begin
               st_d   = ST_OFF;
               ramp_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         set_q  <= '0;
         ramp_q <= '0;
         fast_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         set_q  <= set_d;
         ramp_q <= ramp_d;
         fast_q <= in_ov_i && !stop_i && (st_q != ST_LOCK);
      end
   end

   assign st_o    = st_q;
   assign ramp_o  = ramp_q;
   assign sw_on_o = (st_q == ST_ON);
   assign fast_o  = fast_q;

   assert_ramp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_q != $past(ramp_q)) |-> (ramp_q == $past(ramp_q) + 1'b1) || (ramp_q == '0));

   assert_on_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_on_o |-> (ramp_q == '1));

   assert_inov_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ov_i && !stop_i) |=> !sw_on_o && (ramp_q == '0));

   assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCK && !stop_i) |=> (st_q == ST_LOCK));

   assert_stop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (st_q == ST_OFF) && !fast_q);

endmodule

// File: rtl/chg_guard.sv
module chg_guard #(
   parameter int unsigned TICK_DIV     = 200,
   parameter int unsigned SETTLE_TICKS = 10000,
   parameter int unsigned BLANK_BOV    = 180,
   parameter int unsigned BLANK_OC     = 170,
   parameter int unsigned RAMP_W       = 6,
   parameter int unsigned EVT_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_i,
   input  logic              dis_i,
   input  logic              in_ov_i,
   input  logic              bat_ov_i,
   input  logic              oc_i,
   input  logic              ot_trip_i,
   input  logic              ot_release_i,
   output logic              sw_on_o,
   output logic              fast_off_o,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              warn_n_o
);
   import chg_guard_pkg::*;

   if (TICK_DIV < 1 || SETTLE_TICKS < 1 || BLANK_BOV < 2 || BLANK_OC < 2 ||
       RAMP_W < 2 || EVT_W < 1) begin : g_bad_cfg
      $error("chg_guard: parameter out of range");
   end

   logic                 tick;
   logic                 stop;
   logic                 ot_hot_q;
   logic                 arm;
   logic                 hold;
   logic [N_BLANKED-1:0] flags;
   logic [N_BLANKED-1:0] evt_vec;
   logic [N_BLANKED-1:0] last_vec;
   guard_st_e            st;

   assign stop  = por_i | dis_i;
   assign hold  = bat_ov_i | oc_i;
   assign arm   = (st == ST_RAMP) || (st == ST_ON);
   assign flags[IDX_BOV] = bat_ov_i;
   assign flags[IDX_OC]  = oc_i;

   // trip has priority over release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ot_hot_q <= 1'b0;
      else if (ot_trip_i)    ot_hot_q <= 1'b1;
      else if (ot_release_i) ot_hot_q <= 1'b0;
   end

   chg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   for (genvar gi = 0; gi < N_BLANKED; gi++) begin : g_filt
      localparam int unsigned BT = (gi == IDX_BOV) ? BLANK_BOV : BLANK_OC;
      chg_blank_filt #(.BLANK_TICKS(BT), .EVT_W(EVT_W)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (stop),
         .tick_i (tick),
         .arm_i  (arm),
         .flag_i (flags[gi]),
         .evt_o  (evt_vec[gi]),
         .last_o (last_vec[gi])
      );
   end

   chg_seq #(.SETTLE_TICKS(SETTLE_TICKS), .RAMP_W(RAMP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .stop_i   (stop),
      .in_ov_i  (in_ov_i),
      .ot_hot_i (ot_hot_q),
      .hold_i   (hold),
      .evt_i    (|evt_vec),
      .lock_i   (|(evt_vec & last_vec)),
      .st_o     (st),
      .ramp_o   (ramp_o),
      .sw_on_o  (sw_on_o),
      .fast_o   (fast_off_o)
   );

   assign warn_n_o = ~(fast_off_o | ot_hot_q | (st == ST_RETRY) | (st == ST_LOCK));

   assert_ot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ot_trip_i |-> ##2 !sw_on_o);

   assert_inov_warn_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ov_i && !stop) |=> !warn_n_o);

   assert_por_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      por_i |=> !sw_on_o && !fast_off_o);

endmodule

// File: tb/chg_guard_bench.sv
`timescale 1ns/1ps
module chg_guard_bench;

   localparam int unsigned DIV   = 2;
   localparam int unsigned SET   = 5;
   localparam int unsigned RW    = 4;
   localparam int unsigned BBOV  = 4;
   localparam int unsigned BOC   = 3;
   localparam int unsigned EW    = 4;
   localparam int RMAX      = (1 << RW) - 1;
   localparam int FULL_T    = (SET + RMAX) * DIV;
   localparam int RETRY_T   = RMAX * DIV;
   localparam int N_LOCK    = 1 << EW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por = 1'b1, dis = 1'b0, in_ov = 1'b0, bov = 1'b0, oc = 1'b0;
   logic ot_trip = 1'b0, ot_rel = 1'b0;
   logic sw_on, fast_off, warn_n;
   logic [RW-1:0] ramp;

   int checks = 0;
   int errors = 0;
   int steps_bad = 0;
   int cyc = 0;
   logic warn_at_off, fast_at_off;

   always #2.5 clk = ~clk;

   chg_guard #(.TICK_DIV(DIV), .SETTLE_TICKS(SET), .BLANK_BOV(BBOV),
               .BLANK_OC(BOC), .RAMP_W(RW), .EVT_W(EW)) u_chg_guard (
      .clk(clk), .rst_n(rst_n), .por_i(por), .dis_i(dis), .in_ov_i(in_ov),
      .bat_ov_i(bov), .oc_i(oc), .ot_trip_i(ot_trip), .ot_release_i(ot_rel),
      .sw_on_o(sw_on), .fast_off_o(fast_off), .ramp_o(ramp), .warn_n_o(warn_n));

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_on(input int maxc, output int n);
      int prev;
      prev = ramp;
      n = 0;
      while (!sw_on && n < maxc) begin
         @(negedge clk);
         n++;
         if (ramp != prev && ramp != prev + 1 && ramp != 0) steps_bad++;
         if (sw_on && ramp != RMAX) steps_bad++;
         prev = ramp;
      end
      if (!sw_on) n = -1;
   endtask

   task automatic fault_run(input bit is_oc, output int t_off, output int t_on);
      @(negedge clk);
      if (is_oc) oc = 1'b1; else bov = 1'b1;
      t_off = 0;
      do begin
         @(negedge clk);
         t_off++;
      end while (sw_on && t_off < 60);
      warn_at_off = warn_n;
      fast_at_off = fast_off;
      if (is_oc) oc = 1'b0; else bov = 1'b0;
      wait_on(120, t_on);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int t, t_off, t_on, bad, recov;
      bit still_on, warn_ok;

      idle(3);
      rst_n = 1'b1;
      idle(20);
      // R1: held off during power-on reset
      chk(!sw_on && ramp == 0, "R1 switch off in por", sw_on, 0);
      chk(warn_n && !fast_off, "R1 warn high fast low in por", {warn_n, fast_off}, 2);

      // R2: delayed soft start
      @(negedge clk) por = 1'b0;
      wait_on(200, t);
      chk(t >= FULL_T - 4 && t <= FULL_T + 4, "R2 power-up delay", t, FULL_T);
      chk(ramp == RMAX, "R2 ramp at full scale", ramp, RMAX);
      chk(steps_bad == 0, "R2 ramp steps by one", steps_bad, 0);
      chk(warn_n, "R11 warn high while on", warn_n, 1);

      // R3: input overvoltage, immediate fast off
      @(negedge clk) in_ov = 1'b1;
      @(negedge clk);
      chk(!sw_on && ramp == 0, "R3 off next cycle", sw_on, 0);
      chk(fast_off, "R3 fast path", fast_off, 1);
      chk(!warn_n, "R11 warn low on input ov", warn_n, 0);
      idle(30);
      chk(!sw_on, "R4 stays off while ov", sw_on, 0);
      in_ov = 1'b0;
      wait_on(200, t);
      chk(t >= FULL_T - 4 && t <= FULL_T + 4, "R4 full wait after ov", t, FULL_T);

      // R4: overvoltage present before the wait ends
      @(negedge clk) por = 1'b1;
      idle(3);
      in_ov = 1'b1;
      por = 1'b0;
      bad = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (sw_on) bad++;
      end
      chk(bad == 0, "R4 never on with early ov", bad, 0);
      chk(!warn_n, "R11 warn low during early ov", warn_n, 0);
      in_ov = 1'b0;
      wait_on(200, t);
      chk(t >= FULL_T - 4 && t <= FULL_T + 4, "R4 on after early ov clears", t, FULL_T);

      // R5: short battery pulse ignored
      @(negedge clk) bov = 1'b1;
      still_on = 1'b1; warn_ok = 1'b1;
      for (int i = 0; i < int'((BBOV - 1) * DIV); i++) begin
         @(negedge clk);
         if (!sw_on) still_on = 1'b0;
         if (!warn_n) warn_ok = 1'b0;
      end
      bov = 1'b0;
      idle(5);
      chk(still_on && sw_on, "R5 short pulse ignored", sw_on, 1);
      chk(warn_ok, "R11 warn high in blanking window", warn_ok, 1);

      // R5/R7: blanked battery fault and retry
      fault_run(1'b0, t_off, t_on);
      chk(t_off >= int'((BBOV - 1) * DIV) && t_off <= int'(BBOV * DIV + 2),
          "R5 blanking time", t_off, BBOV * DIV);
      chk(!fast_at_off, "R5 slow path", fast_at_off, 0);
      chk(!warn_at_off, "R11 warn low after blanked fault", warn_at_off, 1'b0);
      chk(t_on >= RETRY_T - 4 && t_on <= RETRY_T + 4, "R7 retry without wait", t_on, RETRY_T);

      // R6: overcurrent
      @(negedge clk) oc = 1'b1;
      still_on = 1'b1;
      for (int i = 0; i < int'((BOC - 1) * DIV); i++) begin
         @(negedge clk);
         if (!sw_on) still_on = 1'b0;
      end
      oc = 1'b0;
      idle(5);
      chk(still_on && sw_on, "R6 short oc pulse ignored", sw_on, 1);
      fault_run(1'b1, t_off, t_on);
      chk(t_off >= int'((BOC - 1) * DIV) && t_off <= int'(BOC * DIV + 2),
          "R6 blanking time", t_off, BOC * DIV);
      chk(!fast_at_off, "R6 slow path", fast_at_off, 0);
      chk(t_on >= RETRY_T - 4 && t_on <= RETRY_T + 4, "R7 retry after oc", t_on, RETRY_T);

      // R8: battery events up to the latch (one already counted)
      recov = 0;
      for (int k = 2; k < N_LOCK; k++) begin
         fault_run(1'b0, t_off, t_on);
         if (t_on > 0) recov++;
      end
      chk(recov == N_LOCK - 2, "R8 recovery below limit", recov, N_LOCK - 2);
      fault_run(1'b0, t_off, t_on);
      chk(t_on == -1, "R8 latched on last event", t_on, -1);
      @(negedge clk) bov = 1'b1;
      oc = 1'b1;
      idle(10);
      bov = 1'b0;
      oc = 1'b0;
      idle(60);
      chk(!sw_on && !warn_n, "R8 latch holds, warn low", {sw_on, warn_n}, 0);

      // R10: enable toggle clears
      @(negedge clk) dis = 1'b1;
      idle(3);
      chk(!sw_on && !fast_off, "R10 disabled off", {sw_on, fast_off}, 0);
      chk(warn_n, "R11 warn high while disabled", warn_n, 1);
      dis = 1'b0;
      wait_on(200, t);
      chk(t >= FULL_T - 4 && t <= FULL_T + 4, "R10 full wait after enable", t, FULL_T);
      fault_run(1'b0, t_off, t_on);
      chk(t_on > 0, "R10 counters cleared by enable", t_on, RETRY_T);

      // R8: overcurrent counter on its own (battery count is 1 here)
      recov = 0;
      for (int k = 1; k < N_LOCK; k++) begin
         fault_run(1'b1, t_off, t_on);
         if (t_on > 0) recov++;
      end
      chk(recov == N_LOCK - 1, "R8 oc recovery below limit", recov, N_LOCK - 1);
      fault_run(1'b1, t_off, t_on);
      chk(t_on == -1, "R8 oc latched", t_on, -1);

      // R10: power cycle clears the latch
      @(negedge clk) por = 1'b1;
      idle(3);
      por = 1'b0;
      wait_on(200, t);
      chk(t >= FULL_T - 4 && t <= FULL_T + 4, "R10 por clears latch", t, FULL_T);

      // R10: disable while on
      @(negedge clk) dis = 1'b1;
      @(negedge clk);
      chk(!sw_on && !fast_off, "R10 off next cycle slow", {sw_on, fast_off}, 0);
      dis = 1'b0;
      wait_on(200, t);

      // R9: over-temperature
      @(negedge clk) ot_trip = 1'b1;
      @(negedge clk) ot_trip = 1'b0;
      @(negedge clk);
      chk(!sw_on, "R9 off within two cycles", sw_on, 0);
      chk(!warn_n, "R11 warn low on thermal trip", warn_n, 0);
      idle(50);
      chk(!sw_on, "R9 stays off until release", sw_on, 0);
      ot_trip = 1'b1;
      ot_rel = 1'b1;
      @(negedge clk);
      ot_trip = 1'b0;
      ot_rel = 1'b0;
      idle(40);
      chk(!sw_on, "R9 trip wins over release", sw_on, 0);
      ot_rel = 1'b1;
      @(negedge clk) ot_rel = 1'b0;
      wait_on(120, t);
      chk(t >= RETRY_T - 4 && t <= RETRY_T + 4, "R9 ramp after release", t, RETRY_T);

      chk(steps_bad == 0, "R2 ramp steps over the run", steps_bad, 0);
      summary();
      $finish;
   end

endmodule